// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block handles a translation-buffer miss. It resolves the miss by reading a two-level page table held in physical memory. A miss request supplies the 32-bit virtual address that missed, together with the current root register, which holds the physical base of the first-level table. The walker then issues at most two word reads on a simple request/response memory port, one read per level. Each read address is formed from a table base and an index field of the virtual address. All table accesses use physical addresses, so the walker itself never needs translation.

When both levels hold resident entries, the walker emits a one-cycle refill pulse carrying three things: the virtual page tag, the physical page number and the permission bits of the leaf entry. The translation buffer stores these as a new entry. If either level returns an entry whose resident bit is clear, the walk stops at once and a one-cycle page-fault pulse is raised instead. No refill is produced in that case, and no further memory read is made.

The walker serves one miss at a time and has at most one memory read in flight. A new miss is taken only when it is idle.

Top module: `pt_walk_engine`

## Requirements
- R1: After reset the walker is idle: `miss_ready` is 1, and `mem_req_valid`, `fill_valid` and `fault_valid` are 0.
- R2: A miss is accepted only on a cycle where `miss_ready` is 1, and `miss_ready` is 1 only while idle. `miss_valid` asserted during a walk has no effect. The first memory request appears the cycle after acceptance.
- R3: The first read address is `{root_base[31:12], 12'b0} + 4 * vaddr[31:22]`. The low 12 bits of `root_base` are ignored. The root and the virtual address are sampled on the acceptance cycle, and later changes on those inputs do not affect the walk.
- R4: The second read address is `{L1.page[31:12], 12'b0} + 4 * vaddr[21:12]`, where L1 is the first-level entry returned.
- R5: `mem_req_valid` is a one-cycle pulse. No new request is made until the response to the previous one has arrived, so at most one read is outstanding.
- R6: A `mem_rsp_valid` pulse that arrives while no read is outstanding is ignored: it produces no request, refill or fault, and it does not change the walk.
- R7: Entry layout: bit 0 is resident, bit 1 is readable, bit 2 is writable, bit 3 is dirty, and bits 31..12 are the page number. Bits 11..4 are ignored.
- R8: When both entries are resident, `fill_valid` pulses with the following outputs: `fill_tag` = vaddr[31:12]; `fill_ppn` = leaf[31:12]; `fill_perm` = {dirty, writable, readable}, with readable in bit 0, writable in bit 1 and dirty in bit 2. `fault_valid` stays 0.
- R9: If the first-level entry is non-resident, `fault_valid` pulses, no second read is issued, and `fill_valid` stays 0.
- R10: If the second-level entry is non-resident, `fault_valid` pulses and `fill_valid` stays 0.
- R11: `fill_valid` and `fault_valid` are each high for exactly one cycle, and `miss_ready` is 1 again on the cycle after either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_vaddr | input | 32 | Virtual address that missed |
| root_base | input | 32 | Physical base of the first-level table (low 12 bits ignored) |
| miss_ready | output | 1 | Walker idle and able to take a miss |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | 32 | Physical word address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| fill_valid | output | 1 | One-cycle refill pulse |
| fill_tag | output | 20 | Virtual page number of the refill |
| fill_ppn | output | 20 | Physical page number of the refill |
| fill_perm | output | 3 | {dirty, writable, readable} of the leaf |
| fault_valid | output | 1 | One-cycle page-fault pulse |

## Verification
The bench targets five kinds of corner case, each tied to a specific wrong behaviour:

- Non-resident entries at each level. A walker that kept going after a non-resident first-level entry would issue a stray second read, or refill from a page number that is really a disk page.
- Root and virtual address inputs changed in the middle of a walk. A design that failed to capture them on acceptance would read from the wrong table.
- Miss requests and stray responses injected while a read is in flight, or while idle. A design that did not gate these would restart the walk or act on junk data.
- Response latencies from zero to several cycles. A wrong wait-state transition shows up here as a lost response or a duplicated request.
- The fill fields themselves. A swapped permission bit or a misplaced index field produces a refill with the wrong permission or page number.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_RD1,
      WS_WT1,
      WS_RD2,
      WS_WT2,
      WS_DONE,
      WS_FAULT
   } walk_state_t;

   // entry bit positions (R7)
   localparam int unsigned PTE_PRESENT_BIT = 0;
   localparam int unsigned PTE_READ_BIT    = 1;
   localparam int unsigned PTE_WRITE_BIT   = 2;
   localparam int unsigned PTE_DIRTY_BIT   = 3;

   typedef struct packed {
      logic dirty;
      logic writable;
      logic readable;
   } perm_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int unsigned PA_W      = 32,
   parameter int unsigned OFS_W     = 12,
   parameter int unsigned IDX_W     = 10,
   parameter int unsigned PTE_BYTES = 4,
   localparam int unsigned PG_W     = PA_W - OFS_W
) (
   input  logic [PG_W-1:0]  base_page,
   input  logic [IDX_W-1:0] index,
   output logic [PA_W-1:0]  entry_addr
);

   logic [PA_W-1:0] base_addr;
   logic [PA_W-1:0] offset;

   assign base_addr = {base_page, {OFS_W{1'b0}}};

   generate
      if ((PTE_BYTES & (PTE_BYTES - 1)) == 0) begin : g_shift
         localparam int unsigned SH = $clog2(PTE_BYTES);
         assign offset = PA_W'(index) << SH;
      end else begin : g_mul
         assign offset = PA_W'(index) * PA_W'(PTE_BYTES);
      end
   endgenerate

   assign entry_addr = base_addr + offset;

endmodule

// File: rtl/ptw_pte_field.sv
module ptw_pte_field
   import ptw_pkg::*;
#(
   parameter int unsigned PTE_W = 32,
   parameter int unsigned OFS_W = 12,
   localparam int unsigned PG_W = PTE_W - OFS_W
) (
   input  logic [PTE_W-1:0] entry,
   output logic             present,
   output perm_t            perm,
   output logic [PG_W-1:0]  page
);

   initial begin
      assert (OFS_W > PTE_DIRTY_BIT)
         else $error("ptw_pte_field: flag bits overlap page number");
   end

   assign present       = entry[PTE_PRESENT_BIT];
   assign perm.readable = entry[PTE_READ_BIT];
   assign perm.writable = entry[PTE_WRITE_BIT];
   assign perm.dirty    = entry[PTE_DIRTY_BIT];
   assign page          = entry[PTE_W-1:OFS_W];

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
   import ptw_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        miss_valid,
   input  logic        rsp_valid,
   input  logic        rsp_present,
   output walk_state_t state,
   output logic        accept,
   output logic        take_l1,
   output logic        take_l2
);

   walk_state_t state_nx;

   assign accept  = (state == WS_IDLE) && miss_valid;
   assign take_l1 = (state == WS_WT1) && rsp_valid;
   assign take_l2 = (state == WS_WT2) && rsp_valid;

   always_comb begin
      state_nx = state;
      unique case (state)
         WS_IDLE:  if (miss_valid) state_nx = WS_RD1;
         WS_RD1:   state_nx = WS_WT1;
         WS_WT1:   if (rsp_valid) state_nx = rsp_present ? WS_RD2 : WS_FAULT;
         WS_RD2:   state_nx = WS_WT2;
         WS_WT2:   if (rsp_valid) state_nx = rsp_present ? WS_DONE : WS_FAULT;
         WS_DONE:  state_nx = WS_IDLE;
         WS_FAULT: state_nx = WS_IDLE;
         default:  state_nx = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= WS_IDLE;
      else        state <= state_nx;
   end

   // R9: after a first-level fault no second-level state is entered
   assert_no_l2_after_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (take_l1 && !rsp_present) |=> (state == WS_FAULT));

   // R6: a response outside a wait state leaves the state sequence alone
   assert_stray_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && state == WS_IDLE && !miss_valid) |=> (state == WS_IDLE));

endmodule

// File: rtl/pt_walk_engine.sv
module pt_walk_engine
   import ptw_pkg::*;
#(
   parameter int unsigned VA_W      = 32,
   parameter int unsigned PA_W      = 32,
   parameter int unsigned OFS_W     = 12,
   parameter int unsigned IDX_W     = 10,
   parameter int unsigned PTE_BYTES = 4,
   localparam int unsigned PTE_W    = 8 * PTE_BYTES,
   localparam int unsigned VPN_W    = VA_W - OFS_W,
   localparam int unsigned PG_W     = PA_W - OFS_W,
   localparam int unsigned LEVELS   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_valid,
   input  logic [VA_W-1:0]  miss_vaddr,
   input  logic [PA_W-1:0]  root_base,
   output logic             miss_ready,
   output logic             mem_req_valid,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic             fill_valid,
   output logic [VPN_W-1:0] fill_tag,
   output logic [PG_W-1:0]  fill_ppn,
   output logic [2:0]       fill_perm,
   output logic             fault_valid
);

   initial begin
      assert (VA_W == LEVELS * IDX_W + OFS_W)
         else $error("pt_walk_engine: address split does not cover VA_W");
      assert (PTE_W == PA_W)
         else $error("pt_walk_engine: entry width must equal PA_W");
      assert (IDX_W + $clog2(PTE_BYTES) <= OFS_W)
         else $error("pt_walk_engine: a table must fit in one page");
   end

   walk_state_t     state;
   logic            accept, take_l1, take_l2;
   logic            rsp_present;
   perm_t           rsp_perm;
   logic [PG_W-1:0] rsp_page;

   logic [VPN_W-1:0] vpn_q;
   logic [PG_W-1:0]  root_pg_q;
   logic [PG_W-1:0]  l2_pg_q;
   logic [PG_W-1:0]  leaf_pg_q;
   perm_t            leaf_perm_q;

   ptw_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .miss_valid  (miss_valid),
      .rsp_valid   (mem_rsp_valid),
      .rsp_present (rsp_present),
      .state       (state),
      .accept      (accept),
      .take_l1     (take_l1),
      .take_l2     (take_l2)
   );

   ptw_pte_field #(.PTE_W(PTE_W), .OFS_W(OFS_W)) u_rsp_dec (
      .entry   (mem_rsp_data),
      .present (rsp_present),
      .perm    (rsp_perm),
      .page    (rsp_page)
   );

   // captured request and walk state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpn_q       <= '0;
         root_pg_q   <= '0;
         l2_pg_q     <= '0;
         leaf_pg_q   <= '0;
         leaf_perm_q <= '0;
      end else begin
         if (accept) begin
            vpn_q     <= miss_vaddr[VA_W-1:OFS_W];
            root_pg_q <= root_base[PA_W-1:OFS_W];
         end
         if (take_l1 && rsp_present) l2_pg_q <= rsp_page;
         if (take_l2) begin
            leaf_pg_q   <= rsp_page;
            leaf_perm_q <= rsp_perm;
         end
      end
   end

   // one address generator per level
   logic [PA_W-1:0] lvl_addr [LEVELS];

   generate
      for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
         localparam int unsigned HI = VPN_W - 1 - lv * IDX_W;
         logic [PG_W-1:0] base_pg;
         if (lv == 0) begin : g_root
            assign base_pg = root_pg_q;
         end else begin : g_inner
            assign base_pg = l2_pg_q;
         end
         ptw_addr_gen #(
            .PA_W(PA_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .PTE_BYTES(PTE_BYTES)
         ) u_gen (
            .base_page  (base_pg),
            .index      (vpn_q[HI -: IDX_W]),
            .entry_addr (lvl_addr[lv])
         );
      end
   endgenerate

   assign miss_ready    = (state == WS_IDLE);
   assign mem_req_valid = (state == WS_RD1) || (state == WS_RD2);
   assign mem_req_addr  = (state == WS_RD2) ? lvl_addr[1] : lvl_addr[0];
   assign fill_valid    = (state == WS_DONE);
   assign fault_valid   = (state == WS_FAULT);
   assign fill_tag      = vpn_q;
   assign fill_ppn      = leaf_pg_q;
   assign fill_perm     = {leaf_perm_q.dirty, leaf_perm_q.writable, leaf_perm_q.readable};

   // R5: request is a single-cycle pulse
   assert_req_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);

   // R2: an accepted miss issues a read on the next cycle
   assert_accept_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_ready && miss_valid) |=> (mem_req_valid && !miss_ready));

   // R2: no request while the walker reports idle
   assert_busy_when_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !miss_ready);

   // R8: refill and fault never coincide
   assert_fill_fault_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_valid && fault_valid));

   // R11: single-cycle result pulses, then idle
   assert_fill_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> (!fill_valid && miss_ready));
   assert_fault_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |=> (!fault_valid && miss_ready));

   // R10: a fault follows a response with the resident bit clear
   assert_fault_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> ($past(mem_rsp_valid) && !$past(mem_rsp_data[PTE_PRESENT_BIT])));

   // R7: a refill follows a resident leaf response
   assert_fill_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> ($past(mem_rsp_valid) && $past(mem_rsp_data[PTE_PRESENT_BIT])));

endmodule

// File: tb/pt_walk_engine_test.sv
module pt_walk_engine_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        miss_valid;
   logic [31:0] miss_vaddr;
   logic [31:0] root_base;
   logic        miss_ready;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        fill_valid;
   logic [19:0] fill_tag;
   logic [19:0] fill_ppn;
   logic [2:0]  fill_perm;
   logic        fault_valid;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   pt_walk_engine uut (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .root_base(root_base),
      .miss_ready(miss_ready),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_ppn(fill_ppn),
      .fill_perm(fill_perm), .fault_valid(fault_valid)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   // table contents: mode 0 hashed residency, 1 L1 absent, 2 L2 absent, 3 all resident
   function automatic logic [31:0] pte_fn(input logic [31:0] addr, input int lvl, input int mode);
      logic [31:0] h;
      logic        pres;
      h = addr * 32'h9E37_79B1;
      h = h ^ (h >> 15);
      case (mode)
         1:       pres = (lvl != 1);
         2:       pres = (lvl != 2);
         3:       pres = 1'b1;
         default: pres = |h[9:8];
      endcase
      return {h[31:12], h[11:4], h[3:1], pres};
   endfunction

   task automatic walk(input logic [31:0] va, input logic [31:0] root,
                       input int mode, input int lat_max, input bit noise);
      logic [31:0] e1, e2, l1, l2;
      logic        exp_fault;
      int          exp_req, nreq, pend, cyc;
      bit          outstanding, finished;
      logic [31:0] pdata;

      e1 = {root[31:12], 12'b0} + {20'b0, va[31:22], 2'b0};
      l1 = pte_fn(e1, 1, mode);
      e2 = '0; l2 = '0;
      if (!l1[0]) begin
         exp_fault = 1'b1; exp_req = 1;
      end else begin
         e2 = {l1[31:12], 12'b0} + {20'b0, va[21:12], 2'b0};
         l2 = pte_fn(e2, 2, mode);
         exp_fault = !l2[0]; exp_req = 2;
      end

      @(negedge clk);
      check(miss_ready, "R2", "ready before miss", 32'(miss_ready), 32'd1);
      miss_valid = 1'b1; miss_vaddr = va; root_base = root;
      nreq = 0; pend = 0; outstanding = 0; finished = 0; cyc = 0; pdata = '0;

      while (!finished && cyc < 64) begin
         @(negedge clk);
         cyc++;
         miss_valid    = 1'b0;
         mem_rsp_valid = 1'b0;
         mem_rsp_data  = $urandom;
         if (noise) begin
            root_base  = $urandom;
            miss_vaddr = $urandom;
            if ($urandom_range(0, 3) == 0 && !fill_valid && !fault_valid) miss_valid = 1'b1;
         end
         if (fill_valid || fault_valid) begin
            finished = 1;
            miss_valid = 1'b0;
         end else begin
            if (miss_ready) check(0, "R2", "ready during walk", 32'd1, 32'd0);
            if (outstanding) begin
               if (pend == 0) begin
                  mem_rsp_valid = 1'b1; mem_rsp_data = pdata; outstanding = 0;
               end else pend--;
            end else if (noise && $urandom_range(0, 2) == 0) begin
               mem_rsp_valid = 1'b1;   // stray response, must be ignored (R6)
            end
            if (mem_req_valid) begin
               if (outstanding) check(0, "R5", "request while outstanding", 32'd1, 32'd0);
               nreq++;
               if (nreq == 1) check(mem_req_addr == e1, "R3", "L1 address", mem_req_addr, e1);
               else if (nreq == 2) check(mem_req_addr == e2, "R4", "L2 address", mem_req_addr, e2);
               pdata = pte_fn(mem_req_addr, nreq, mode);
               pend = $urandom_range(0, lat_max);
               outstanding = 1;
               if (mem_rsp_valid && !outstanding) mem_rsp_valid = 1'b0;
            end
         end
      end

      if (!finished) begin
         check(0, "R8", "walk did not finish", 32'(cyc), 32'd64);
      end else begin
         check(nreq == exp_req, exp_fault && exp_req == 1 ? "R9" : "R5",
               "read count", 32'(nreq), 32'(exp_req));
         if (exp_fault) begin
            check(fault_valid && !fill_valid, exp_req == 1 ? "R9" : "R10",
                  "fault outcome", {30'b0, fill_valid, fault_valid}, 32'd1);
         end else begin
            check(fill_valid && !fault_valid, "R8", "fill outcome",
                  {30'b0, fill_valid, fault_valid}, 32'd2);
            check(fill_tag == va[31:12], "R8", "fill tag", 32'(fill_tag), 32'(va[31:12]));
            check(fill_ppn == l2[31:12], "R7", "fill page", 32'(fill_ppn), 32'(l2[31:12]));
            check(fill_perm == {l2[3], l2[2], l2[1]}, "R7", "fill perm",
                  32'(fill_perm), 32'({l2[3], l2[2], l2[1]}));
         end
         @(negedge clk);
         check(!fill_valid && !fault_valid && miss_ready, "R11", "pulse then idle",
               {29'b0, miss_ready, fill_valid, fault_valid}, 32'd4);
      end
      mem_rsp_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      rst_n = 1'b0; miss_valid = 1'b0; miss_vaddr = '0; root_base = '0;
      mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(miss_ready && !mem_req_valid && !fill_valid && !fault_valid, "R1", "reset state",
            {28'b0, miss_ready, mem_req_valid, fill_valid, fault_valid}, 32'd8);

      // R6: responses while idle are ignored
      for (int i = 0; i < 4; i++) begin
         mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_F00F;
         @(negedge clk);
         check(miss_ready && !mem_req_valid && !fill_valid && !fault_valid, "R6",
               "idle stray response", {28'b0, miss_ready, mem_req_valid, fill_valid, fault_valid}, 32'd8);
      end
      mem_rsp_valid = 1'b0;

      // directed corners
      walk(32'h0000_0000, 32'h0000_0000, 3, 0, 0);   // R8 lowest indices
      walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 0, 0);   // R3 root low bits ignored, top indices
      walk(32'h1234_5678, 32'h0040_0000, 1, 2, 0);   // R9 L1 absent
      walk(32'h8765_4321, 32'h0080_0ABC, 2, 2, 0);   // R10 L2 absent
      walk(32'hDEAD_BEEF, 32'h00C0_0000, 3, 5, 1);   // R2 R6 noise mid-walk
      walk(32'h003F_F000, 32'h7FFF_F123, 3, 0, 1);   // R4 second index all ones

      // constrained random walks
      for (int n = 0; n < 300; n++) begin
         walk($urandom, $urandom, $urandom_range(0, 3), $urandom_range(0, 4), n[0]);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule